// File: doc/BRIEF.md
# Page Write Commit Controller

This block sits behind the serial command decoder of a small nonvolatile memory. When the decoder sees an array-write command, it hands the block a base address. It then streams the data bytes in, one per handshake. The block gathers them in a one-page buffer. The low address bits advance after each byte and wrap inside the page, so a long burst overwrites its own earlier bytes. The high bits never change.

When chip select is released, the block decides whether to commit. It commits only if the release lands on a byte boundary and at least one byte was taken. It then enters a self-timed programming interval of `PROG_CYCLES` system clocks and raises `busy` for that whole interval. During the interval it walks the buffer once, from offset 0 upward, and emits one array write per clock for each loaded offset. Before each write it asks an external protection checker whether the address is locked. When the interval ends, it pulses a request that clears the write-enable latch.

The same timed path commits status-register writes. For those, the last received byte goes out once on a separate strobe in place of the array writes. The byte input is a valid/ready stream. `byte_ready` is low exactly while programming is in progress. A sender must hold a byte until it is accepted. Bytes offered while no write is open are accepted and discarded.

Top module: `pgw_page_ctrl`

## Requirements
- R1: After reset, `busy`, `mem_we`, `sr_we` and `wel_clr` are low and `byte_ready` is high.
- R2: A write opened at `wr_base` stores its first byte at page offset `wr_base[4:0]`. Each further accepted byte goes to the next offset modulo 32. Every array write carries `wr_base[ADDR_W-1:5]` as its upper address bits.
- R3: When more than 32 bytes are accepted, later bytes replace earlier ones at the same offset. Only the newest value is written.
- R4: A `cs_rise` commits only when `byte_whole` is high in that cycle and at least one byte was accepted since the write opened. Otherwise the write is dropped: no array write, no `busy`, no `wel_clr`.
- R5: On a commit, `busy` rises in the cycle after the one in which `cs_rise` is sampled. It stays high for exactly `PROG_CYCLES` cycles.
- R6: During `busy`, array writes come at most one per clock, in ascending offset order starting at offset 0. A write is made only for offsets loaded in this transfer, with address `{upper bits, offset}` and the buffered byte.
- R7: A loaded offset whose address the protection checker reports as locked (`prot_hit` high while `prot_addr` shows it) is not written.
- R8: `wel_clr` is a single-cycle pulse in the first cycle after `busy` falls. It occurs only after a committed write.
- R9: A `wr_start` with `wel` low is ignored. The bytes and `cs_rise` that follow cause no write, no `busy` and no `wel_clr`.
- R10: `byte_ready` is low while `busy` is high. A `wr_start`, byte or `cs_rise` presented during `busy` has no effect on the writes made or on the state after `busy` ends.
- R11: A write opened with `wr_to_status` high makes no array write. Instead it raises `sr_we` for one cycle, the first cycle of `busy`, with `sr_wdata` equal to the last byte accepted, and ends with `wel_clr` as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_start | input | 1 | Pulse: open a write transfer |
| wr_to_status | input | 1 | With `wr_start`: target is the status register |
| wr_base | input | ADDR_W | With `wr_start`: first byte address |
| wel | input | 1 | Current write-enable latch value |
| byte_valid | input | 1 | Data byte offered |
| byte_ready | output | 1 | Data byte can be taken (low while programming) |
| byte_data | input | DATA_W | Data byte |
| byte_whole | input | 1 | Front end is at a byte boundary |
| cs_rise | input | 1 | Pulse: chip select released |
| prot_addr | output | ADDR_W | Address being checked for protection |
| prot_hit | input | 1 | Combinational verdict: `prot_addr` is locked |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |
| sr_we | output | 1 | Status register write strobe |
| sr_wdata | output | DATA_W | Status register write data |
| busy | output | 1 | Programming interval in progress |
| wel_clr | output | 1 | Pulse: clear the write-enable latch |

## Verification
The hardest case to reach is a page whose offset wrapped and that also straddles a protection boundary. Here the commit order (offset 0 first) differs from the arrival order, and only some buffered bytes may land. The stimulus opens a write two bytes below the page end with the protection limit set mid-page. It then checks through the scoreboard that the two wrapped low offsets are written first and the locked high ones never are. A second hard case is traffic during programming. The bench drives a new start, bytes and a chip-select release while `busy` is high, and the scoreboard must see no extra write.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic [1:0] {
    PG_IDLE = 2'd0,
    PG_FILL = 2'd1,
    PG_BURN = 2'd2
  } pg_state_e;
endpackage

// File: rtl/pgw_page_buf.sv
module pgw_page_buf #(
  parameter int PAGE_BYTES = 32,
  parameter int DATA_W     = 8,
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_loaded,
  output logic              any_loaded
);
  logic [DATA_W-1:0]     slot_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mark_q;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_off == OFF_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mark_q[g] <= 1'b0;
      else if (clr) mark_q[g] <= 1'b0;
      else if (hit) mark_q[g] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (hit) slot_q[g] <= wr_data;
    end
  end

  assign rd_data    = slot_q[rd_off];
  assign rd_loaded  = mark_q[rd_off];
  assign any_loaded = |mark_q;

  // R2
  fill_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> any_loaded);

  // R6
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !wr_en) |=> !any_loaded);
endmodule

// File: rtl/pgw_timer.sv
module pgw_timer #(
  parameter int CYCLES   = 64,
  localparam int CNT_W   = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic running,
  output logic last
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load && !run_q) begin
      cnt_q <= CNT_W'(CYCLES - 1);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign running = run_q;
  assign last    = run_q && (cnt_q == '0);

  // R5
  start_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> $past(load));
endmodule

// File: rtl/pgw_page_ctrl.sv
module pgw_page_ctrl
  import pgw_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int PAGE_BYTES  = 32,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_start,
  input  logic              wr_to_status,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic              wel,
  input  logic              byte_valid,
  output logic              byte_ready,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              byte_whole,
  input  logic              cs_rise,
  output logic [ADDR_W-1:0] prot_addr,
  input  logic              prot_hit,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              sr_we,
  output logic [DATA_W-1:0] sr_wdata,
  output logic              busy,
  output logic              wel_clr
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int HI_W   = ADDR_W - OFF_W;
  localparam int SCAN_W = OFF_W + 1;

  pg_state_e         state_q;
  logic [HI_W-1:0]   hi_q;
  logic [OFF_W-1:0]  off_q;
  logic              to_sr_q;
  logic [DATA_W-1:0] last_q;
  logic [SCAN_W-1:0] scan_q;
  logic              welclr_q;

  logic              take;
  logic              fill_wr;
  logic              open_wr;
  logic              commit;
  logic              scanning;
  logic [OFF_W-1:0]  scan_off;
  logic [DATA_W-1:0] buf_data;
  logic              buf_loaded;
  logic              buf_any;
  logic              t_run;
  logic              t_last;

  assign byte_ready = (state_q != PG_BURN);
  assign take       = byte_valid && byte_ready;
  assign fill_wr    = take && (state_q == PG_FILL);
  assign open_wr    = (state_q == PG_IDLE) && wr_start && wel;
  assign commit     = (state_q == PG_FILL) && cs_rise && byte_whole && buf_any;
  assign scanning   = (state_q == PG_BURN) && (scan_q < SCAN_W'(PAGE_BYTES));
  assign scan_off   = scan_q[OFF_W-1:0];

  pgw_page_buf #(
    .PAGE_BYTES (PAGE_BYTES),
    .DATA_W     (DATA_W)
  ) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (open_wr),
    .wr_en      (fill_wr),
    .wr_off     (off_q),
    .wr_data    (byte_data),
    .rd_off     (scan_off),
    .rd_data    (buf_data),
    .rd_loaded  (buf_loaded),
    .any_loaded (buf_any)
  );

  pgw_timer #(
    .CYCLES  (PROG_CYCLES)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (commit),
    .running (t_run),
    .last    (t_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= PG_IDLE;
      hi_q     <= '0;
      off_q    <= '0;
      to_sr_q  <= 1'b0;
      last_q   <= '0;
      scan_q   <= '0;
      welclr_q <= 1'b0;
    end else begin
      welclr_q <= 1'b0;
      unique case (state_q)
        PG_IDLE: begin
          if (open_wr) begin
            state_q <= PG_FILL;
            hi_q    <= wr_base[ADDR_W-1:OFF_W];
            off_q   <= wr_base[OFF_W-1:0];
            to_sr_q <= wr_to_status;
          end
        end
        PG_FILL: begin
          if (fill_wr) begin
            off_q  <= off_q + 1'b1;
            last_q <= byte_data;
          end
          if (commit) begin
            state_q <= PG_BURN;
            scan_q  <= '0;
          end else if (cs_rise) begin
            state_q <= PG_IDLE;
          end
        end
        PG_BURN: begin
          if (scanning) scan_q <= scan_q + 1'b1;
          if (t_last) begin
            state_q  <= PG_IDLE;
            welclr_q <= 1'b1;
          end
        end
        default: state_q <= PG_IDLE;
      endcase
    end
  end

  assign prot_addr = {hi_q, scan_off};
  assign mem_addr  = {hi_q, scan_off};
  assign mem_wdata = buf_data;
  assign mem_we    = scanning && !to_sr_q && buf_loaded && !prot_hit;
  assign sr_we     = (state_q == PG_BURN) && to_sr_q && (scan_q == '0);
  assign sr_wdata  = last_q;
  assign busy      = (state_q == PG_BURN);
  assign wel_clr   = welclr_q;

  // R6
  write_in_burn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (busy && t_run));

  // R4
  commit_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(cs_rise) && $past(byte_whole)));

  // R8
  welclr_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |-> ($past(busy) && !busy));

  // R11
  sr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_we |=> !sr_we);

  // R10
  ready_low_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !byte_ready);
endmodule

// File: tb/pgw_page_ctrl_test.sv
module pgw_page_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;
  localparam int PB = 32;
  localparam int DW = 8;
  localparam int PC = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_start = 1'b0, wr_to_status = 1'b0, wel = 1'b0;
  logic [AW-1:0] wr_base = '0;
  logic          byte_valid = 1'b0, byte_whole = 1'b0, cs_rise = 1'b0;
  logic [DW-1:0] byte_data = '0;
  logic          byte_ready, prot_hit, mem_we, sr_we, busy, wel_clr;
  logic [AW-1:0] prot_addr, mem_addr;
  logic [DW-1:0] mem_wdata, sr_wdata;

  logic          prot_on = 1'b0;
  logic [AW-1:0] prot_lo = '0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always_comb prot_hit = prot_on && (prot_addr >= prot_lo);

  pgw_page_ctrl #(.ADDR_W(AW), .PAGE_BYTES(PB), .DATA_W(DW), .PROG_CYCLES(PC)) uut (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_to_status(wr_to_status),
    .wr_base(wr_base), .wel(wel), .byte_valid(byte_valid), .byte_ready(byte_ready),
    .byte_data(byte_data), .byte_whole(byte_whole), .cs_rise(cs_rise),
    .prot_addr(prot_addr), .prot_hit(prot_hit), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .sr_we(sr_we), .sr_wdata(sr_wdata), .busy(busy),
    .wel_clr(wel_clr)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // scoreboard
  typedef struct packed { logic [AW-1:0] a; logic [DW-1:0] d; } wr_t;
  wr_t exp_q[$];

  // reference page model
  logic [DW-1:0] m_buf [PB];
  bit            m_ld  [PB];
  bit            m_act = 0, m_sr = 0;
  int            m_hi = 0, m_off = 0;
  logic [DW-1:0] m_last = '0;

  // monitor state
  int            run_len = 0, n_welclr = 0, n_sr = 0, n_mem = 0;
  logic [DW-1:0] last_sr = '0;
  logic          prev_busy = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) begin
        n_mem++;
        if (exp_q.size() == 0) begin
          check(0, "R6", "unexpected array write addr", int'(mem_addr), 0);
        end else begin
          wr_t e;
          e = exp_q.pop_front();
          check(mem_addr == e.a, "R2/R6", "write address", int'(mem_addr), int'(e.a));
          check(mem_wdata == e.d, "R3/R6", "write data", int'(mem_wdata), int'(e.d));
        end
      end
      if (busy) run_len++;
      else if (run_len > 0) begin
        check(run_len == PC, "R5", "busy length", run_len, PC);
        run_len = 0;
      end
      if (wel_clr) begin
        n_welclr++;
        check(prev_busy && !busy, "R8", "wel_clr placement", int'({prev_busy, busy}), 2);
      end
      if (sr_we) begin
        n_sr++;
        last_sr = sr_wdata;
      end
      prev_busy = busy;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic t_start(input logic [AW-1:0] base, input bit to_sr, input bit en);
    wr_start = 1'b1; wr_base = base; wr_to_status = to_sr; wel = en;
    tick();
    wr_start = 1'b0; wr_to_status = 1'b0;
    if (en) begin
      m_act = 1; m_sr = to_sr;
      m_hi  = int'(base) / PB;
      m_off = int'(base) % PB;
      for (int i = 0; i < PB; i++) m_ld[i] = 0;
    end
  endtask

  task automatic t_byte(input logic [DW-1:0] d);
    byte_valid = 1'b1; byte_data = d;
    tick();
    byte_valid = 1'b0;
    if (m_act) begin
      m_buf[m_off] = d; m_ld[m_off] = 1;
      m_off = (m_off + 1) % PB;
      m_last = d;
    end
  endtask

  task automatic t_end(input bit whole, output bit committed);
    bit any;
    any = 0;
    for (int i = 0; i < PB; i++) if (m_ld[i]) any = 1;
    committed = m_act && whole && any;
    if (committed && !m_sr) begin
      for (int i = 0; i < PB; i++) begin
        logic [AW-1:0] a;
        a = AW'(m_hi * PB + i);
        if (m_ld[i] && !(prot_on && a >= prot_lo)) exp_q.push_back('{a: a, d: m_buf[i]});
      end
    end
    m_act = 0;
    cs_rise = 1'b1; byte_whole = whole;
    tick();
    cs_rise = 1'b0; byte_whole = 1'b0;
  endtask

  task automatic t_drain();
    while (busy) tick();
    repeat (3) tick();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit c;
    int wc;
    int mc;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(busy == 0, "R1", "busy", int'(busy), 0);
    check(byte_ready == 1, "R1", "byte_ready", int'(byte_ready), 1);
    check(mem_we == 0 && sr_we == 0 && wel_clr == 0, "R1", "strobes",
          int'({mem_we, sr_we, wel_clr}), 0);
    rst_n = 1'b1;
    tick();

    // R2 R5 R6 R8: plain 4-byte write
    t_start(11'h105, 0, 1);
    t_byte(8'h11); t_byte(8'h22); t_byte(8'h33); t_byte(8'h44);
    t_end(1, c);
    check(busy == 1, "R5", "busy after commit", int'(busy), 1);
    t_drain();
    check(n_welclr == 1, "R8", "wel_clr count", n_welclr, 1);
    check(exp_q.size() == 0, "R6", "pending writes", exp_q.size(), 0);

    // R2 wrap within page: offsets 30,31,0
    t_start(11'h01E, 0, 1);
    t_byte(8'hA0); t_byte(8'hA1); t_byte(8'hA2);
    t_end(1, c);
    t_drain();
    check(exp_q.size() == 0, "R2", "wrap writes done", exp_q.size(), 0);

    // R3 overflow: 34 bytes
    t_start(11'h040, 0, 1);
    for (int i = 0; i < 34; i++) t_byte(DW'(8'h50 + i));
    t_end(1, c);
    t_drain();
    check(exp_q.size() == 0, "R3", "overflow writes done", exp_q.size(), 0);

    // R4 abandon on partial byte and on empty transfer
    wc = n_welclr; mc = n_mem;
    t_start(11'h200, 0, 1);
    t_byte(8'h77); t_byte(8'h78);
    t_end(0, c);
    check(busy == 0, "R4", "busy after partial-byte release", int'(busy), 0);
    t_start(11'h210, 0, 1);
    t_end(1, c);
    check(busy == 0, "R4", "busy after empty transfer", int'(busy), 0);
    repeat (5) tick();
    check(n_welclr == wc, "R4", "wel_clr count", n_welclr, wc);
    check(n_mem == mc, "R4", "array writes", n_mem, mc);

    // R7 protection across wrapped page
    prot_on = 1'b1; prot_lo = 11'h2F0;
    t_start(11'h2FE, 0, 1);
    t_byte(8'hC0); t_byte(8'hC1); t_byte(8'hC2); t_byte(8'hC3);
    mc = n_mem;
    t_end(1, c);
    t_drain();
    check(n_mem - mc == 2, "R7", "unprotected writes", n_mem - mc, 2);
    prot_on = 1'b0;

    // R9 write enable clear
    wc = n_welclr; mc = n_mem;
    t_start(11'h300, 0, 0);
    t_byte(8'h01); t_byte(8'h02);
    t_end(1, c);
    check(busy == 0, "R9", "busy without wel", int'(busy), 0);
    repeat (3) tick();
    check(n_welclr == wc && n_mem == mc, "R9", "effects without wel",
          n_welclr - wc + n_mem - mc, 0);

    // R10 traffic during programming is ignored
    t_start(11'h120, 0, 1);
    t_byte(8'hE1); t_byte(8'hE2);
    t_end(1, c);
    check(byte_ready == 0, "R10", "byte_ready while busy", int'(byte_ready), 0);
    wr_start = 1'b1; wr_base = 11'h3C0; wel = 1'b1; tick(); wr_start = 1'b0;
    byte_valid = 1'b1; byte_data = 8'hEE; tick(); tick(); byte_valid = 1'b0;
    cs_rise = 1'b1; byte_whole = 1'b1; tick(); cs_rise = 1'b0; byte_whole = 1'b0;
    t_drain();
    cs_rise = 1'b1; byte_whole = 1'b1; tick(); cs_rise = 1'b0; byte_whole = 1'b0;
    check(busy == 0, "R10", "busy after ignored traffic", int'(busy), 0);
    repeat (3) tick();
    check(exp_q.size() == 0, "R10", "pending writes", exp_q.size(), 0);

    // R11 status register commit
    wc = n_welclr; mc = n_mem;
    t_start(11'h000, 1, 1);
    t_byte(8'h8C); t_byte(8'h8A);
    t_end(1, c);
    t_drain();
    check(n_sr == 1, "R11", "sr_we count", n_sr, 1);
    check(last_sr == 8'h8A, "R11", "sr_wdata", int'(last_sr), 8'h8A);
    check(n_mem == mc, "R11", "array writes", n_mem - mc, 0);
    check(n_welclr == wc + 1, "R11", "wel_clr count", n_welclr, wc + 1);

    check(exp_q.size() == 0, "R6", "final queue", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule